// File: doc/BRIEF.md
# Atomic Multi-Byte Register Access Controller

This block sits between a byte-wide host register port and a set of register fields that are wider than one byte. A wide field is spread over two or three byte addresses, and the controller makes each field behave as one consistent unit. Host writes to a field's bytes are held in a staging buffer. The assembled value is handed to the register store as a single commit pulse, and only once every byte of the field has been written exactly once with no unrelated access in between. The bytes may be written in any order.

A host read of any byte of a field captures the whole field in a snapshot. The remaining bytes are then served from that snapshot until all of them have been read. Only one sequence can be open at a time. Any access that does not continue the open sequence ends it and sets a sticky abort flag. Such an access can be a different address, the same byte a second time, or the other direction. The access that caused the abort is still carried out normally, and if it targets another wide field it opens a new sequence there.

The field table is set by parameters. For each field it gives the byte addresses, the byte count, the bit width and a read-only marker. Byte slot k of a field carries bits 8k+7..8k. The defaults are:
- field 0: 19 bits at 0x00C, 0x00D, 0x007, writable;
- field 1: 16 bits at 0x03C, 0x03D, writable;
- field 2: 16 bits at 0x070, 0x071, read-only.

The abort flag sits in bit 0 of a status byte at STATUS_ADDR, which defaults to 0x1F0.

Top module: `mbr_atomic_access`

## Requirements
- R1: When the last missing byte of a writable field is written, commitValid is high for exactly the following cycle. In that cycle, commitField holds the field index and commitData holds the assembled value, with byte slot k at bits 8k+7..8k. Bytes may arrive in any order.
- R2: A write sequence that is interrupted produces no commit and sets abortFlag in the cycle after the interrupting access. Interruptions include an access to an unmapped address and a read of the same field.
- R3: A read of the first byte of a field returns that byte of the live value. Later reads of the field's other bytes return the values captured at that first read, even if the live value has changed, until every byte has been read. Idle cycles do not disturb an open sequence.
- R4: After a read sequence has been interrupted, the next read of that field returns the current live value and not the old snapshot, and abortFlag is set.
- R5: Accessing a byte that has already been accessed in the open sequence aborts that sequence. The repeated access then opens a fresh sequence containing that byte.
- R6: An access to a different wide field aborts the open sequence and opens a new sequence for the new field, and that new sequence can complete.
- R7: A write to a read-only field never produces a commit and opens no sequence. Reads of a read-only field follow R3.
- R8: A read of STATUS_ADDR returns abortFlag in bit 0, with bits 7..1 zero. Writing 1 to bit 0 clears the flag. Writing 0 has no effect. If an abort and a clear happen on the same access, the flag stays set.
- R9: Field bits at or above the field's width read back as 0, and commitData has them cleared.
- R10: hostRdata is updated in the cycle after a read access. A reset leaves hostRdata, commitValid and abortFlag at 0 and discards any partly written sequence.
- R11: Accesses made while no sequence is open, and sequences that complete normally, never set abortFlag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hostValid | input | 1 | Host access strobe, one access per cycle |
| hostWrite | input | 1 | 1 = write, 0 = read |
| hostAddr | input | ADDR_W (9) | Byte address |
| hostWdata | input | 8 | Write byte |
| fieldLive | input | NUM_FIELDS*DATA_W (72) | Live field values, field f at bits f*DATA_W upward |
| hostRdata | output | 8 | Read byte, valid the cycle after a read |
| commitValid | output | 1 | One-cycle commit pulse |
| commitField | output | FIDX_W (2) | Index of the committed field |
| commitData | output | DATA_W (24) | Committed field value, masked to the field width |
| abortFlag | output | 1 | Sticky abort status |

## Verification
The hardest case to reach is an access that aborts one sequence and opens another in the same cycle. The second sequence must then be shown to complete with the right data. This can happen through a repeated byte, a write that hits a field being read, or a hop to another field. The stimulus table places these accesses back to back, each followed by the remaining bytes of the new sequence, and checks the resulting commit value. It also covers a clear of the status flag issued while a sequence is open, where the set must win. Snapshot freezing is shown by changing the live input in the same cycle as the first byte read, and again before the later byte reads.

// File: rtl/mbr_pkg.sv
`timescale 1ns/1ps
package mbr_pkg;

  typedef enum logic [1:0] {
    RD_ZERO   = 2'd0,
    RD_LIVE   = 2'd1,
    RD_SNAP   = 2'd2,
    RD_STATUS = 2'd3
  } rd_sel_e;

  // strobes from sequence control to datapath
  typedef struct packed {
    logic    loadSnap;
    logic    stageByte;
    logic    commit;
    logic    setAbort;
    logic    clearAbort;
    logic    rdEn;
    rd_sel_e rdSel;
  } dp_strobe_t;

endpackage

// File: rtl/mbr_addr_decode.sv
`timescale 1ns/1ps
module mbr_addr_decode #(
  parameter int NUM_FIELDS = 3,
  parameter int MAX_BYTES  = 3,
  parameter int ADDR_W     = 9,
  parameter logic [NUM_FIELDS*MAX_BYTES*ADDR_W-1:0] FIELD_ADDR = '0,
  parameter logic [NUM_FIELDS*8-1:0] FIELD_NBYTES = '0,
  parameter logic [NUM_FIELDS-1:0]   FIELD_RO = '0,
  parameter logic [ADDR_W-1:0]       STATUS_ADDR = '0,
  localparam int FIDX_W = (NUM_FIELDS > 1) ? $clog2(NUM_FIELDS) : 1,
  localparam int BIDX_W = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1
) (
  input  logic [ADDR_W-1:0]    hostAddr,
  output logic                 fieldHit,
  output logic [FIDX_W-1:0]    fieldIdx,
  output logic [BIDX_W-1:0]    byteIdx,
  output logic                 fieldRo,
  output logic [MAX_BYTES-1:0] fullMask,
  output logic                 statusHit
);

  logic [MAX_BYTES-1:0] maskTab [NUM_FIELDS];

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
    for (genvar b = 0; b < MAX_BYTES; b++) begin : g_byte
      assign maskTab[f][b] = (b < int'(FIELD_NBYTES[f*8 +: 8]));
    end
  end

  always_comb begin
    fieldHit = 1'b0;
    fieldIdx = '0;
    byteIdx  = '0;
    for (int f = 0; f < NUM_FIELDS; f++) begin
      for (int b = 0; b < MAX_BYTES; b++) begin
        if (!fieldHit && (b < int'(FIELD_NBYTES[f*8 +: 8])) &&
            (hostAddr == FIELD_ADDR[(f*MAX_BYTES+b)*ADDR_W +: ADDR_W])) begin
          fieldHit = 1'b1;
          fieldIdx = FIDX_W'(f);
          byteIdx  = BIDX_W'(b);
        end
      end
    end
    fieldRo   = FIELD_RO[fieldIdx];
    fullMask  = maskTab[fieldIdx];
    statusHit = (hostAddr == STATUS_ADDR);
  end

endmodule

// File: rtl/mbr_seq_ctrl.sv
`timescale 1ns/1ps
module mbr_seq_ctrl
  import mbr_pkg::*;
#(
  parameter int NUM_FIELDS = 3,
  parameter int MAX_BYTES  = 3,
  localparam int FIDX_W = (NUM_FIELDS > 1) ? $clog2(NUM_FIELDS) : 1,
  localparam int BIDX_W = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 hostValid,
  input  logic                 hostWrite,
  input  logic                 wBit0,
  input  logic                 fieldHit,
  input  logic [FIDX_W-1:0]    fieldIdx,
  input  logic [BIDX_W-1:0]    byteIdx,
  input  logic                 fieldRo,
  input  logic [MAX_BYTES-1:0] fullMask,
  input  logic                 statusHit,
  output dp_strobe_t           st
);

  logic                 active;
  logic                 actRead;
  logic [FIDX_W-1:0]    actField;
  logic [MAX_BYTES-1:0] seenMask;

  logic [MAX_BYTES-1:0] byteBit;
  logic [MAX_BYTES-1:0] newSeen;
  logic isFieldRd, isFieldWr, startable, cont, done;

  always_comb begin
    byteBit   = MAX_BYTES'(1) << byteIdx;
    isFieldRd = hostValid && fieldHit && !hostWrite;
    isFieldWr = hostValid && fieldHit && hostWrite && !fieldRo;
    startable = isFieldRd || isFieldWr;
    cont      = active && startable && (actField == fieldIdx) &&
                (actRead == isFieldRd) && ((seenMask & byteBit) == '0);
    newSeen   = cont ? (seenMask | byteBit) : byteBit;
    done      = (newSeen == fullMask);

    st            = '0;
    st.loadSnap   = isFieldRd && !cont;
    st.stageByte  = isFieldWr;
    st.commit     = isFieldWr && done;
    st.setAbort   = hostValid && active && !cont;
    st.clearAbort = hostValid && hostWrite && statusHit && wBit0;
    st.rdEn       = hostValid && !hostWrite;
    if (statusHit)      st.rdSel = RD_STATUS;
    else if (isFieldRd) st.rdSel = cont ? RD_SNAP : RD_LIVE;
    else                st.rdSel = RD_ZERO;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active   <= 1'b0;
      actRead  <= 1'b0;
      actField <= '0;
      seenMask <= '0;
    end else if (hostValid) begin
      if (startable && !done) begin
        active   <= 1'b1;
        actRead  <= isFieldRd;
        actField <= fieldIdx;
        seenMask <= newSeen;
      end else begin
        active   <= 1'b0;
        seenMask <= '0;
      end
    end
  end

  // R1: a commit closes the sequence
  assert_commit_ends_seq_R1: assert property (@(posedge clk) disable iff (!rstN)
    st.commit |=> !active);

  // R5: an open sequence always holds at least one accessed byte
  assert_open_seq_partial_R5: assert property (@(posedge clk) disable iff (!rstN)
    active |-> (seenMask != '0));

  // R3: idle cycles leave the tracking state untouched
  assert_idle_holds_seq_R3: assert property (@(posedge clk) disable iff (!rstN)
    !hostValid |=> ($stable(seenMask) && $stable(active)));

endmodule

// File: rtl/mbr_datapath.sv
`timescale 1ns/1ps
module mbr_datapath
  import mbr_pkg::*;
#(
  parameter int NUM_FIELDS = 3,
  parameter int MAX_BYTES  = 3,
  parameter logic [NUM_FIELDS*8-1:0] FIELD_WIDTH = '0,
  localparam int DATA_W = 8 * MAX_BYTES,
  localparam int FIDX_W = (NUM_FIELDS > 1) ? $clog2(NUM_FIELDS) : 1,
  localparam int BIDX_W = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  dp_strobe_t                   st,
  input  logic [FIDX_W-1:0]            fieldIdx,
  input  logic [BIDX_W-1:0]            byteIdx,
  input  logic [7:0]                   hostWdata,
  input  logic [NUM_FIELDS*DATA_W-1:0] fieldLive,
  output logic [7:0]                   hostRdata,
  output logic                         commitValid,
  output logic [FIDX_W-1:0]            commitField,
  output logic [DATA_W-1:0]            commitData,
  output logic                         abortFlag
);

  logic [DATA_W-1:0] wMask   [NUM_FIELDS];
  logic [DATA_W-1:0] liveArr [NUM_FIELDS];

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
    assign wMask[f]   = (DATA_W'(1) << FIELD_WIDTH[f*8 +: 8]) - DATA_W'(1);
    assign liveArr[f] = fieldLive[f*DATA_W +: DATA_W] & wMask[f];
  end

  // one buffer serves as write staging and as read snapshot
  logic [DATA_W-1:0] seqBuf;
  logic [DATA_W-1:0] liveSel;
  logic [DATA_W-1:0] merged;

  always_comb begin
    liveSel = liveArr[fieldIdx];
    merged  = seqBuf;
    merged[byteIdx*8 +: 8] = hostWdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seqBuf <= '0;
    end else if (st.loadSnap) begin
      seqBuf <= liveSel;
    end else if (st.stageByte) begin
      seqBuf[byteIdx*8 +: 8] <= hostWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      commitValid <= 1'b0;
      commitField <= '0;
      commitData  <= '0;
    end else begin
      commitValid <= st.commit;
      if (st.commit) begin
        commitField <= fieldIdx;
        commitData  <= merged & wMask[fieldIdx];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hostRdata <= '0;
    end else if (st.rdEn) begin
      case (st.rdSel)
        RD_LIVE:   hostRdata <= liveSel[byteIdx*8 +: 8];
        RD_SNAP:   hostRdata <= seqBuf[byteIdx*8 +: 8];
        RD_STATUS: hostRdata <= {7'b0, abortFlag};
        default:   hostRdata <= '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      abortFlag <= 1'b0;
    end else if (st.setAbort) begin
      abortFlag <= 1'b1;
    end else if (st.clearAbort) begin
      abortFlag <= 1'b0;
    end
  end

  // R9: committed bits above the field width are zero
  assert_commit_masked_R9: assert property (@(posedge clk) disable iff (!rstN)
    commitValid |-> ((commitData & ~wMask[commitField]) == '0));

  // R8: the flag only falls through a write-one clear
  assert_abort_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (abortFlag && !st.clearAbort) |=> abortFlag);

endmodule

// File: rtl/mbr_atomic_access.sv
`timescale 1ns/1ps
module mbr_atomic_access
  import mbr_pkg::*;
#(
  parameter int NUM_FIELDS = 3,
  parameter int MAX_BYTES  = 3,
  parameter int ADDR_W     = 9,
  // slot (f,b) at bits [(f*MAX_BYTES+b)*ADDR_W +: ADDR_W]
  parameter logic [NUM_FIELDS*MAX_BYTES*ADDR_W-1:0] FIELD_ADDR =
    {9'h000, 9'h071, 9'h070,
     9'h000, 9'h03D, 9'h03C,
     9'h007, 9'h00D, 9'h00C},
  parameter logic [NUM_FIELDS*8-1:0] FIELD_NBYTES = {8'd2, 8'd2, 8'd3},
  parameter logic [NUM_FIELDS*8-1:0] FIELD_WIDTH  = {8'd16, 8'd16, 8'd19},
  parameter logic [NUM_FIELDS-1:0]   FIELD_RO     = 3'b100,
  parameter logic [ADDR_W-1:0]       STATUS_ADDR  = 9'h1F0,
  localparam int DATA_W = 8 * MAX_BYTES,
  localparam int FIDX_W = (NUM_FIELDS > 1) ? $clog2(NUM_FIELDS) : 1,
  localparam int BIDX_W = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         hostValid,
  input  logic                         hostWrite,
  input  logic [ADDR_W-1:0]            hostAddr,
  input  logic [7:0]                   hostWdata,
  input  logic [NUM_FIELDS*DATA_W-1:0] fieldLive,
  output logic [7:0]                   hostRdata,
  output logic                         commitValid,
  output logic [FIDX_W-1:0]            commitField,
  output logic [DATA_W-1:0]            commitData,
  output logic                         abortFlag
);

  logic                 fieldHit;
  logic [FIDX_W-1:0]    fieldIdx;
  logic [BIDX_W-1:0]    byteIdx;
  logic                 fieldRo;
  logic [MAX_BYTES-1:0] fullMask;
  logic                 statusHit;
  dp_strobe_t           st;

  mbr_addr_decode #(
    .NUM_FIELDS(NUM_FIELDS), .MAX_BYTES(MAX_BYTES), .ADDR_W(ADDR_W),
    .FIELD_ADDR(FIELD_ADDR), .FIELD_NBYTES(FIELD_NBYTES),
    .FIELD_RO(FIELD_RO), .STATUS_ADDR(STATUS_ADDR)
  ) u_decode (
    .hostAddr(hostAddr), .fieldHit(fieldHit), .fieldIdx(fieldIdx),
    .byteIdx(byteIdx), .fieldRo(fieldRo), .fullMask(fullMask),
    .statusHit(statusHit)
  );

  mbr_seq_ctrl #(
    .NUM_FIELDS(NUM_FIELDS), .MAX_BYTES(MAX_BYTES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .hostValid(hostValid), .hostWrite(hostWrite),
    .wBit0(hostWdata[0]), .fieldHit(fieldHit), .fieldIdx(fieldIdx),
    .byteIdx(byteIdx), .fieldRo(fieldRo), .fullMask(fullMask),
    .statusHit(statusHit), .st(st)
  );

  mbr_datapath #(
    .NUM_FIELDS(NUM_FIELDS), .MAX_BYTES(MAX_BYTES), .FIELD_WIDTH(FIELD_WIDTH)
  ) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .fieldIdx(fieldIdx), .byteIdx(byteIdx),
    .hostWdata(hostWdata), .fieldLive(fieldLive), .hostRdata(hostRdata),
    .commitValid(commitValid), .commitField(commitField),
    .commitData(commitData), .abortFlag(abortFlag)
  );

  // R7: read-only fields never produce a commit
  assert_ro_never_commits_R7: assert property (@(posedge clk) disable iff (!rstN)
    commitValid |-> !FIELD_RO[commitField]);

endmodule

// File: tb/tb_mbr_atomic_access.sv
`timescale 1ns/1ps
module tb_mbr_atomic_access;

  localparam logic [1:0] OP_IDLE = 2'd0, OP_RD = 2'd1, OP_WR = 2'd2;
  localparam logic [23:0] L0  = 24'hFF1234;  // field0 live, masked 0x071234
  localparam logic [23:0] L0B = 24'h05AA55;
  localparam logic [23:0] L1  = 24'h00ABCD;
  localparam logic [23:0] L2  = 24'h00BEEF;
  localparam logic [23:0] L2B = 24'h00CAFE;

  typedef struct packed {
    logic [1:0]  op;
    logic [8:0]  addr;
    logic [7:0]  wdata;
    logic [23:0] live0;
    logic [23:0] live2;
    logic [7:0]  expRd;
    logic        expC;
    logic [1:0]  expF;
    logic [23:0] expD;
    logic        expA;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 37;
  localparam vec_t VEC [0:NV-1] = '{
    '{OP_WR, 9'h00D, 8'h22, L0,  L2,  8'h00, 1'b0, 2'd0, 24'h0,      1'b0, 4'd1},  // R1
    '{OP_WR, 9'h007, 8'hFF, L0,  L2,  8'h00, 1'b0, 2'd0, 24'h0,      1'b0, 4'd1},  // R1
    '{OP_WR, 9'h00C, 8'h11, L0,  L2,  8'h00, 1'b1, 2'd0, 24'h072211, 1'b0, 4'd1},  // R1 R9
    '{OP_RD, 9'h00D, 8'h00, L0,  L2,  8'h12, 1'b0, 2'd0, 24'h0,      1'b0, 4'd3},  // R3
    '{OP_RD, 9'h00C, 8'h00, L0B, L2,  8'h34, 1'b0, 2'd0, 24'h0,      1'b0, 4'd3},  // R3 frozen
    '{OP_RD, 9'h007, 8'h00, L0B, L2,  8'h07, 1'b0, 2'd0, 24'h0,      1'b0, 4'd9},  // R9 + frozen
    '{OP_RD, 9'h00C, 8'h00, L0B, L2,  8'h55, 1'b0, 2'd0, 24'h0,      1'b0, 4'd11}, // R11
    '{OP_RD, 9'h03C, 8'h00, L0B, L2,  8'hCD, 1'b0, 2'd0, 24'h0,      1'b1, 4'd6},  // R6
    '{OP_RD, 9'h03D, 8'h00, L0B, L2,  8'hAB, 1'b0, 2'd0, 24'h0,      1'b1, 4'd6},  // R6
    '{OP_WR, 9'h1F0, 8'h00, L0B, L2,  8'h00, 1'b0, 2'd0, 24'h0,      1'b1, 4'd8},  // R8 write 0
    '{OP_RD, 9'h1F0, 8'h00, L0B, L2,  8'h01, 1'b0, 2'd0, 24'h0,      1'b1, 4'd8},  // R8
    '{OP_WR, 9'h1F0, 8'h01, L0B, L2,  8'h00, 1'b0, 2'd0, 24'h0,      1'b0, 4'd8},  // R8 clear
    '{OP_WR, 9'h03C, 8'h99, L0B, L2,  8'h00, 1'b0, 2'd0, 24'h0,      1'b0, 4'd5},  // R5
    '{OP_WR, 9'h03C, 8'h98, L0B, L2,  8'h00, 1'b0, 2'd0, 24'h0,      1'b1, 4'd5},  // R5 repeat
    '{OP_WR, 9'h03D, 8'h77, L0B, L2,  8'h00, 1'b1, 2'd1, 24'h007798, 1'b1, 4'd5},  // R5 restart
    '{OP_WR, 9'h1F0, 8'h01, L0B, L2,  8'h00, 1'b0, 2'd0, 24'h0,      1'b0, 4'd8},  // R8
    '{OP_WR, 9'h070, 8'h12, L0B, L2,  8'h00, 1'b0, 2'd0, 24'h0,      1'b0, 4'd11}, // R11, R7
    '{OP_RD, 9'h070, 8'h00, L0B, L2,  8'hEF, 1'b0, 2'd0, 24'h0,      1'b0, 4'd7},  // R7
    '{OP_WR, 9'h071, 8'h34, L0B, L2,  8'h00, 1'b0, 2'd0, 24'h0,      1'b1, 4'd7},  // R7
    '{OP_RD, 9'h071, 8'h00, L0B, L2B, 8'hCA, 1'b0, 2'd0, 24'h0,      1'b1, 4'd4},  // R4
    '{OP_WR, 9'h1F0, 8'h01, L0B, L2B, 8'h00, 1'b0, 2'd0, 24'h0,      1'b1, 4'd8},  // R8 set wins
    '{OP_WR, 9'h1F0, 8'h01, L0B, L2B, 8'h00, 1'b0, 2'd0, 24'h0,      1'b0, 4'd8},  // R8
    '{OP_WR, 9'h00C, 8'hAB, L0B, L2B, 8'h00, 1'b0, 2'd0, 24'h0,      1'b0, 4'd6},  // R6
    '{OP_WR, 9'h03D, 8'h01, L0B, L2B, 8'h00, 1'b0, 2'd0, 24'h0,      1'b1, 4'd6},  // R6 hop
    '{OP_WR, 9'h03C, 8'h02, L0B, L2B, 8'h00, 1'b1, 2'd1, 24'h000102, 1'b1, 4'd6},  // R6
    '{OP_WR, 9'h1F0, 8'h01, L0B, L2B, 8'h00, 1'b0, 2'd0, 24'h0,      1'b0, 4'd8},  // R8
    '{OP_RD, 9'h007, 8'h00, L0B, L2B, 8'h05, 1'b0, 2'd0, 24'h0,      1'b0, 4'd3},  // R3
    '{OP_WR, 9'h00C, 8'h00, L0B, L2B, 8'h00, 1'b0, 2'd0, 24'h0,      1'b1, 4'd2},  // R2 dir change
    '{OP_WR, 9'h00D, 8'h00, L0B, L2B, 8'h00, 1'b0, 2'd0, 24'h0,      1'b1, 4'd2},  // R2
    '{OP_WR, 9'h007, 8'hF8, L0B, L2B, 8'h00, 1'b1, 2'd0, 24'h000000, 1'b1, 4'd9},  // R9
    '{OP_WR, 9'h1F0, 8'h01, L0B, L2B, 8'h00, 1'b0, 2'd0, 24'h0,      1'b0, 4'd8},  // R8
    '{OP_WR, 9'h00C, 8'h5A, L0B, L2B, 8'h00, 1'b0, 2'd0, 24'h0,      1'b0, 4'd2},  // R2
    '{OP_RD, 9'h050, 8'h00, L0B, L2B, 8'h00, 1'b0, 2'd0, 24'h0,      1'b1, 4'd2},  // R2 interrupt
    '{OP_WR, 9'h00D, 8'h5B, L0B, L2B, 8'h00, 1'b0, 2'd0, 24'h0,      1'b1, 4'd2},  // R2
    '{OP_WR, 9'h007, 8'h01, L0B, L2B, 8'h00, 1'b0, 2'd0, 24'h0,      1'b1, 4'd2},  // R2 no commit
    '{OP_WR, 9'h00C, 8'h5A, L0B, L2B, 8'h00, 1'b1, 2'd0, 24'h015B5A, 1'b1, 4'd1},  // R1
    '{OP_IDLE, 9'h000, 8'h00, L0B, L2B, 8'h00, 1'b0, 2'd0, 24'h0,    1'b1, 4'd11}  // R11
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostValid = 1'b0;
  logic        hostWrite = 1'b0;
  logic [8:0]  hostAddr = '0;
  logic [7:0]  hostWdata = '0;
  logic [71:0] fieldLive = {L2, L1, L0};
  logic [7:0]  hostRdata;
  logic        commitValid;
  logic [1:0]  commitField;
  logic [23:0] commitData;
  logic        abortFlag;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  mbr_atomic_access dut (
    .clk(clk), .rstN(rstN), .hostValid(hostValid), .hostWrite(hostWrite),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .fieldLive(fieldLive),
    .hostRdata(hostRdata), .commitValid(commitValid),
    .commitField(commitField), .commitData(commitData), .abortFlag(abortFlag)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one access: drive at negedge, sample just after the next rising edge
  task automatic access(input logic [1:0] op, input logic [8:0] a, input logic [7:0] d);
    @(negedge clk);
    hostValid = (op != OP_IDLE);
    hostWrite = (op == OP_WR);
    hostAddr  = a;
    hostWdata = d;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    // R10: reset state
    #1;
    chk("R10", "hostRdata at reset", 32'(hostRdata), 32'h0);
    chk("R10", "commitValid at reset", 32'(commitValid), 32'h0);
    chk("R10", "abortFlag at reset", 32'(abortFlag), 32'h0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      string tag;
      @(negedge clk);
      tag = $sformatf("R%0d vec%0d", VEC[i].req, i);
      fieldLive = {VEC[i].live2, L1, VEC[i].live0};
      hostValid = (VEC[i].op != OP_IDLE);
      hostWrite = (VEC[i].op == OP_WR);
      hostAddr  = VEC[i].addr;
      hostWdata = VEC[i].wdata;
      @(posedge clk);
      #1;
      chk(tag, "abortFlag", 32'(abortFlag), 32'(VEC[i].expA));
      chk(tag, "commitValid", 32'(commitValid), 32'(VEC[i].expC));
      if (VEC[i].expC) begin
        chk(tag, "commitField", 32'(commitField), 32'(VEC[i].expF));
        chk(tag, "commitData", 32'(commitData), 32'(VEC[i].expD));
      end
      if (VEC[i].op == OP_RD)
        chk(tag, "hostRdata", 32'(hostRdata), 32'(VEC[i].expRd));
    end

    // R10: reset in the middle of a write sequence discards it
    access(OP_WR, 9'h1F0, 8'h01);
    access(OP_WR, 9'h00C, 8'h10);
    access(OP_WR, 9'h00D, 8'h20);
    @(negedge clk);
    hostValid = 1'b0;
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    chk("R10", "abortFlag after reset", 32'(abortFlag), 32'h0);
    access(OP_WR, 9'h007, 8'h01);
    chk("R10", "no commit after reset", 32'(commitValid), 32'h0);
    chk("R11", "no abort on fresh start", 32'(abortFlag), 32'h0);
    access(OP_WR, 9'h00C, 8'h02);
    chk("R10", "still no commit", 32'(commitValid), 32'h0);
    access(OP_WR, 9'h00D, 8'h03);
    chk("R1", "commit after reset", 32'(commitValid), 32'h1);
    chk("R1", "commit data after reset", 32'(commitData), 32'h010302);
    access(OP_IDLE, 9'h000, 8'h00);
    chk("R1", "commit is one cycle", 32'(commitValid), 32'h0);

    // R10: read data held until the next read
    access(OP_RD, 9'h1F0, 8'h00);
    chk("R10", "status read", 32'(hostRdata), 32'h0);
    access(OP_RD, 9'h03D, 8'h00);
    chk("R10", "read latency", 32'(hostRdata), 32'hAB);
    access(OP_IDLE, 9'h000, 8'h00);
    chk("R10", "rdata held", 32'(hostRdata), 32'hAB);

    @(negedge clk);
    hostValid = 1'b0;
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule